// File: doc/BRIEF.md
# Coherent Write-Back Cache Controller

This block is the per-processor side of a flag-based coherence scheme. It holds a small direct-mapped array of whole blocks and serves full-block loads and stores from its processor. Each line carries a tag, a valid flag and an ownership flag. The ownership flag marks a line as the only copy in the system. While that flag is set, stores proceed locally without any traffic to memory.

Towards memory the controller issues one request at a time on a command port and holds it until a one-cycle DONE pulse arrives. The requests are the fills (shared or exclusive), a request for ownership, and the write-back or drop notices for evicted lines. The shared memory controller can send two commands at any time: copy back an owned block, or take a block away. The controller answers both on a separate response port. It serves them even while its own request is still waiting for DONE, so that the two sides cannot deadlock.

Top module: `cohcache_ctrl`

## Requirements
- R1: Reset clears every valid and ownership flag and leaves `cpu_ack`, `mreq_valid` and `sresp_valid` low. The first access to each line therefore issues exactly one fill request and no eviction notice.
- R2: A load that misses (line invalid or tag different) evicts any valid victim. It then issues a shared fill (`mreq_op` = 0) for its address, returns the filled block with `cpu_ack`, and leaves the line valid and not owned.
- R3: A store that misses evicts any valid victim and issues an exclusive fill (`mreq_op` = 1). On DONE the line holds the stored block, valid and owned.
- R4: A store that hits a valid line that is not owned sends a request for ownership (`mreq_op` = 2) with its address. After DONE the line is owned and holds the new block.
- R5: A store that hits an owned line sends nothing to memory and raises `cpu_ack` in the cycle after the request is seen.
- R6: Evicting a valid victim sends the victim's own address. An owned victim goes out as write-back-and-drop (`mreq_op` = 5) carrying its data. A victim that is not owned goes out as drop only (`mreq_op` = 4). The fill follows only after DONE.
- R7: A load that hits returns the stored block with `cpu_ack` in the cycle after the request is seen, with no memory request.
- R8: A copy-back command (`mcmd_purge` = 0) for an owned valid block produces, one cycle later, a response with `sresp_op` = 3 (write), the block address and its data. The line stays valid but is no longer owned.
- R9: A take-away command (`mcmd_purge` = 1) for a valid block produces, one cycle later, a response of write-back-and-drop (5, with data) if the line was owned, or drop (4) if it was not. The line then becomes invalid.
- R10: A copy-back or take-away command for a block that is not held valid in its line gives no response and leaves the line unchanged. A copy-back command for a valid line that is not owned is ignored in the same way.
- R11: Memory commands are served with the same one-cycle response while the controller's own request is outstanding.
- R12: A take-away command for the line whose ownership request is outstanding is answered with drop. When DONE then arrives, the store installs the line valid and owned with its datum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Block address |
| cpu_wdata | input | DATA_W | Block to store |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Loaded block, valid with `cpu_ack` |
| mreq_valid | output | 1 | Memory request pending, held until `mem_done` |
| mreq_op | output | 3 | 0 fill, 1 exclusive fill, 2 ownership, 4 drop, 5 write-back-and-drop |
| mreq_addr | output | ADDR_W | Block address of the request |
| mreq_data | output | DATA_W | Write-back data |
| mem_done | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | DATA_W | Fill data, valid with `mem_done` |
| mcmd_valid | input | 1 | Memory command strobe, one cycle |
| mcmd_purge | input | 1 | 1 = take away, 0 = copy back |
| mcmd_addr | input | ADDR_W | Block address of the command |
| sresp_valid | output | 1 | Response strobe, one cycle |
| sresp_op | output | 3 | 3 write, 4 drop, 5 write-back-and-drop |
| sresp_addr | output | ADDR_W | Block address of the response |
| sresp_data | output | DATA_W | Block data for write responses |

## Verification
A hit is looked up at the first clock edge after the request, so its `cpu_ack` and data are sampled at the falling edge that follows. The bench requires exactly one cycle there. Memory commands are registered once, so each response is sampled exactly one cycle after the command is driven; an absent or unowned target must show no strobe in that cycle. Misses take a variable number of cycles that depends on the memory latency. For them the bench waits a bounded time for `cpu_ack` and compares the ordered log of memory requests against the sequence that its own model of line flags predicts. Two directed runs issue commands in the middle of a long-latency request to cover R11 and R12.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [2:0] {
        MOP_READ        = 3'd0,
        MOP_READ_EXCL   = 3'd1,
        MOP_EXCLUDE     = 3'd2,
        MOP_WRITE       = 3'd3,
        MOP_EJECT       = 3'd4,
        MOP_WRITE_EJECT = 3'd5
    } mop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_EXCL,
        ST_ACK
    } st_e;

    // notice sent when a valid line leaves the cache
    function automatic mop_e leave_op(input logic owned);
        return owned ? MOP_WRITE_EJECT : MOP_EJECT;
    endfunction

    function automatic mop_e fill_op(input logic store);
        return store ? MOP_READ_EXCL : MOP_READ;
    endfunction

endpackage

// File: rtl/cc_line_store.sv
module cc_line_store #(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output logic              a_valid,
    output logic              a_priv,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output logic              b_valid,
    output logic              b_priv,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              ctl_we,
    input  logic [IDX_W-1:0]  ctl_idx,
    input  logic              ctl_valid,
    input  logic              ctl_priv,
    input  logic [TAG_W-1:0]  ctl_tag,
    input  logic [DATA_W-1:0] ctl_data,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic              snp_valid,
    input  logic              snp_priv
);

    logic [LINES-1:0]  valid_w;
    logic [LINES-1:0]  priv_w;
    logic [TAG_W-1:0]  tag_w  [LINES];
    logic [DATA_W-1:0] data_w [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic              p_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              ctl_sel;
        logic              snp_sel;

        assign ctl_sel = ctl_we && (ctl_idx == IDX_W'(g));
        assign snp_sel = snp_we && (snp_idx == IDX_W'(g));

        // controller completions win over a same-cycle memory command
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                p_q <= 1'b0;
            end else if (ctl_sel) begin
                v_q <= ctl_valid;
                p_q <= ctl_priv;
            end else if (snp_sel) begin
                v_q <= snp_valid;
                p_q <= snp_priv;
            end
        end

        always_ff @(posedge clk) begin
            if (ctl_sel) begin
                t_q <= ctl_tag;
                d_q <= ctl_data;
            end
        end

        assign valid_w[g] = v_q;
        assign priv_w[g]  = p_q;
        assign tag_w[g]   = t_q;
        assign data_w[g]  = d_q;
    end

    assign a_valid = valid_w[a_idx];
    assign a_priv  = priv_w[a_idx];
    assign a_tag   = tag_w[a_idx];
    assign a_data  = data_w[a_idx];
    assign b_valid = valid_w[b_idx];
    assign b_priv  = priv_w[b_idx];
    assign b_tag   = tag_w[b_idx];
    assign b_data  = data_w[b_idx];

endmodule

// File: rtl/cc_snoop.sv
module cc_snoop
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_purge,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              ln_valid,
    input  logic              ln_priv,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              snp_we,
    output logic [IDX_W-1:0]  snp_idx,
    output logic              snp_valid,
    output logic              snp_priv,
    output logic              resp_valid,
    output logic [2:0]        resp_op,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [DATA_W-1:0] resp_data
);

    logic       held;
    logic       act;
    mop_e       op;
    logic       rv_q;
    mop_e       rop_q;
    logic [ADDR_W-1:0] ra_q;
    logic [DATA_W-1:0] rd_q;

    assign rd_idx  = cmd_addr[IDX_W-1:0];
    assign snp_idx = cmd_addr[IDX_W-1:0];
    assign held    = cmd_valid && ln_valid && (ln_tag == cmd_addr[ADDR_W-1:IDX_W]);

    always_comb begin
        snp_we    = 1'b0;
        snp_valid = ln_valid;
        snp_priv  = ln_priv;
        act       = 1'b0;
        op        = MOP_WRITE;
        if (held) begin
            if (cmd_purge) begin
                snp_we    = 1'b1;
                snp_valid = 1'b0;
                snp_priv  = 1'b0;
                act       = 1'b1;
                op        = leave_op(ln_priv);
            end else if (ln_priv) begin
                snp_we    = 1'b1;
                snp_priv  = 1'b0;
                act       = 1'b1;
                op        = MOP_WRITE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q  <= 1'b0;
            rop_q <= MOP_WRITE;
            ra_q  <= '0;
            rd_q  <= '0;
        end else begin
            rv_q  <= act;
            rop_q <= op;
            ra_q  <= cmd_addr;
            rd_q  <= ln_data;
        end
    end

    assign resp_valid = rv_q;
    assign resp_op    = rop_q;
    assign resp_addr  = ra_q;
    assign resp_data  = rd_q;

endmodule

// File: rtl/cc_fsm.sv
module cc_fsm
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_store,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              hold,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              ln_valid,
    input  logic              ln_priv,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              ctl_we,
    output logic [IDX_W-1:0]  ctl_idx,
    output logic              ctl_valid,
    output logic              ctl_priv,
    output logic [TAG_W-1:0]  ctl_tag,
    output logic [DATA_W-1:0] ctl_data,
    output logic              mreq_valid,
    output logic [2:0]        mreq_op,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [DATA_W-1:0] mreq_data,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata
);

    st_e               st_q, st_n;
    logic              r_store;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic              mv_q, mv_n;
    mop_e              mop_q, mop_n;
    logic [ADDR_W-1:0] ma_q, ma_n;
    logic [DATA_W-1:0] md_q, md_n;
    logic [DATA_W-1:0] rd_q, rd_n;
    logic              cap;

    logic [IDX_W-1:0]  c_idx, r_idx;
    logic [TAG_W-1:0]  c_tag, r_tag;
    logic              lk_hit;

    assign c_idx  = cpu_addr[IDX_W-1:0];
    assign c_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign r_idx  = r_addr[IDX_W-1:0];
    assign r_tag  = r_addr[ADDR_W-1:IDX_W];
    assign lk_idx = c_idx;
    assign lk_hit = ln_valid && (ln_tag == c_tag);

    always_comb begin
        st_n      = st_q;
        mv_n      = mv_q;
        mop_n     = mop_q;
        ma_n      = ma_q;
        md_n      = md_q;
        rd_n      = rd_q;
        cap       = 1'b0;
        ctl_we    = 1'b0;
        ctl_idx   = r_idx;
        ctl_valid = 1'b0;
        ctl_priv  = 1'b0;
        ctl_tag   = r_tag;
        ctl_data  = r_wdata;
        unique case (st_q)
            ST_IDLE: begin
                // a memory command in this cycle defers the lookup by a cycle
                if (cpu_req && !hold) begin
                    if (lk_hit && !cpu_store) begin
                        rd_n = ln_data;
                        st_n = ST_ACK;
                    end else if (lk_hit && ln_priv) begin
                        ctl_we    = 1'b1;
                        ctl_idx   = c_idx;
                        ctl_valid = 1'b1;
                        ctl_priv  = 1'b1;
                        ctl_tag   = c_tag;
                        ctl_data  = cpu_wdata;
                        rd_n      = cpu_wdata;
                        st_n      = ST_ACK;
                    end else if (lk_hit) begin
                        cap   = 1'b1;
                        mv_n  = 1'b1;
                        mop_n = MOP_EXCLUDE;
                        ma_n  = cpu_addr;
                        md_n  = cpu_wdata;
                        st_n  = ST_EXCL;
                    end else if (ln_valid) begin
                        // victim leaves the array at once; its state travels in the request
                        cap       = 1'b1;
                        ctl_we    = 1'b1;
                        ctl_idx   = c_idx;
                        ctl_valid = 1'b0;
                        ctl_priv  = 1'b0;
                        ctl_tag   = ln_tag;
                        ctl_data  = ln_data;
                        mv_n      = 1'b1;
                        mop_n     = leave_op(ln_priv);
                        ma_n      = {ln_tag, c_idx};
                        md_n      = ln_data;
                        st_n      = ST_EVICT;
                    end else begin
                        cap   = 1'b1;
                        mv_n  = 1'b1;
                        mop_n = fill_op(cpu_store);
                        ma_n  = cpu_addr;
                        md_n  = cpu_wdata;
                        st_n  = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_done) begin
                    mop_n = fill_op(r_store);
                    ma_n  = r_addr;
                    md_n  = r_wdata;
                    st_n  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_done) begin
                    ctl_we    = 1'b1;
                    ctl_valid = 1'b1;
                    ctl_priv  = r_store;
                    ctl_data  = r_store ? r_wdata : mem_rdata;
                    rd_n      = r_store ? r_wdata : mem_rdata;
                    mv_n      = 1'b0;
                    st_n      = ST_ACK;
                end
            end
            ST_EXCL: begin
                // full-block store: install whole line even if a command dropped it
                if (mem_done) begin
                    ctl_we    = 1'b1;
                    ctl_valid = 1'b1;
                    ctl_priv  = 1'b1;
                    rd_n      = r_wdata;
                    mv_n      = 1'b0;
                    st_n      = ST_ACK;
                end
            end
            ST_ACK:  st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            mv_q    <= 1'b0;
            mop_q   <= MOP_READ;
            ma_q    <= '0;
            md_q    <= '0;
            rd_q    <= '0;
            r_store <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else begin
            st_q  <= st_n;
            mv_q  <= mv_n;
            mop_q <= mop_n;
            ma_q  <= ma_n;
            md_q  <= md_n;
            rd_q  <= rd_n;
            if (cap) begin
                r_store <= cpu_store;
                r_addr  <= cpu_addr;
                r_wdata <= cpu_wdata;
            end
        end
    end

    assign cpu_ack    = (st_q == ST_ACK);
    assign cpu_rdata  = rd_q;
    assign mreq_valid = mv_q;
    assign mreq_op    = mop_q;
    assign mreq_addr  = ma_q;
    assign mreq_data  = md_q;

endmodule

// File: rtl/cohcache_ctrl.sv
module cohcache_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_store,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mreq_valid,
    output logic [2:0]        mreq_op,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [DATA_W-1:0] mreq_data,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mcmd_valid,
    input  logic              mcmd_purge,
    input  logic [ADDR_W-1:0] mcmd_addr,
    output logic              sresp_valid,
    output logic [2:0]        sresp_op,
    output logic [ADDR_W-1:0] sresp_addr,
    output logic [DATA_W-1:0] sresp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx, b_idx;
    logic              a_valid, a_priv, b_valid, b_priv;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic              ctl_we, ctl_valid, ctl_priv;
    logic [IDX_W-1:0]  ctl_idx;
    logic [TAG_W-1:0]  ctl_tag;
    logic [DATA_W-1:0] ctl_data;
    logic              snp_we, snp_valid, snp_priv;
    logic [IDX_W-1:0]  snp_idx;

    cc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .a_valid(a_valid), .a_priv(a_priv), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_valid(b_valid), .b_priv(b_priv), .b_tag(b_tag), .b_data(b_data),
        .ctl_we(ctl_we), .ctl_idx(ctl_idx), .ctl_valid(ctl_valid), .ctl_priv(ctl_priv),
        .ctl_tag(ctl_tag), .ctl_data(ctl_data),
        .snp_we(snp_we), .snp_idx(snp_idx), .snp_valid(snp_valid), .snp_priv(snp_priv)
    );

    cc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_fsm (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_store(cpu_store), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .hold(mcmd_valid),
        .lk_idx(a_idx), .ln_valid(a_valid), .ln_priv(a_priv), .ln_tag(a_tag), .ln_data(a_data),
        .ctl_we(ctl_we), .ctl_idx(ctl_idx), .ctl_valid(ctl_valid), .ctl_priv(ctl_priv),
        .ctl_tag(ctl_tag), .ctl_data(ctl_data),
        .mreq_valid(mreq_valid), .mreq_op(mreq_op), .mreq_addr(mreq_addr), .mreq_data(mreq_data),
        .mem_done(mem_done), .mem_rdata(mem_rdata)
    );

    cc_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_snoop (
        .clk(clk), .rst(rst),
        .cmd_valid(mcmd_valid), .cmd_purge(mcmd_purge), .cmd_addr(mcmd_addr),
        .rd_idx(b_idx), .ln_valid(b_valid), .ln_priv(b_priv), .ln_tag(b_tag), .ln_data(b_data),
        .snp_we(snp_we), .snp_idx(snp_idx), .snp_valid(snp_valid), .snp_priv(snp_priv),
        .resp_valid(sresp_valid), .resp_op(sresp_op), .resp_addr(sresp_addr), .resp_data(sresp_data)
    );

endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ack,
    input logic              mreq_valid,
    input logic [2:0]        mreq_op,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic              mem_done,
    input logic              mcmd_valid,
    input logic              sresp_valid,
    input logic [2:0]        sresp_op
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mreq_valid && !cpu_ack && !sresp_valid));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mem_done) |=> (mreq_valid && $stable(mreq_op) && $stable(mreq_addr)));

    assert_ack_no_pending_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> !mreq_valid);

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    assert_resp_kind_R8: assert property (@(posedge clk) disable iff (rst)
        sresp_valid |-> (sresp_op == 3'd3 || sresp_op == 3'd4 || sresp_op == 3'd5));

    assert_resp_caused_R9: assert property (@(posedge clk) disable iff (rst)
        sresp_valid |-> $past(mcmd_valid));

endmodule

bind cohcache_ctrl cc_checker #(.ADDR_W(ADDR_W)) u_cc_checker (
    .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .mreq_valid(mreq_valid), .mreq_op(mreq_op),
    .mreq_addr(mreq_addr), .mem_done(mem_done), .mcmd_valid(mcmd_valid),
    .sresp_valid(sresp_valid), .sresp_op(sresp_op)
);

// File: tb/cohcache_ctrl_bench.sv
`timescale 1ns/1ps
module cohcache_ctrl_bench;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_store = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          mreq_valid;
    logic [2:0]    mreq_op;
    logic [AW-1:0] mreq_addr;
    logic [DW-1:0] mreq_data;
    logic          mem_done = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mcmd_valid = 1'b0, mcmd_purge = 1'b0;
    logic [AW-1:0] mcmd_addr = '0;
    logic          sresp_valid;
    logic [2:0]    sresp_op;
    logic [AW-1:0] sresp_addr;
    logic [DW-1:0] sresp_data;

    cohcache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_cohcache_ctrl (.*);

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int lat = 2;

    logic [DW-1:0] mem [16];
    logic          mv [NL];
    logic          mp [NL];
    logic [1:0]    mt [NL];
    logic [DW-1:0] md [NL];

    logic [2:0]    lg_op   [8];
    logic [AW-1:0] lg_addr [8];
    logic [DW-1:0] lg_data [8];
    int            lg_n = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // memory side: log each request, answer after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mreq_valid) begin
                if (lg_n < 8) begin
                    lg_op[lg_n]   = mreq_op;
                    lg_addr[lg_n] = mreq_addr;
                    lg_data[lg_n] = mreq_data;
                end
                lg_n++;
                repeat (lat) @(negedge clk);
                mem_rdata = mem[mreq_addr];
                if (mreq_op == 3'd5 || mreq_op == 3'd3) mem[mreq_addr] = mreq_data;
                mem_done = 1'b1;
                @(negedge clk);
                mem_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    task automatic do_access(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        logic [1:0]    ix;
        logic [1:0]    tg;
        bit            hit;
        int            en;
        int            cyc;
        logic [2:0]    eop [2];
        logic [AW-1:0] ea  [2];
        logic [DW-1:0] ed  [2];
        bit            edc [2];
        string         rq  [2];
        string         main_rq;
        logic [DW-1:0] emem;
        ix   = a[1:0];
        tg   = a[3:2];
        hit  = mv[ix] && (mt[ix] == tg);
        emem = mem[a];
        en   = 0;
        if (hit && st && !mp[ix]) begin
            eop[0] = 3'd2; ea[0] = a; ed[0] = '0; edc[0] = 0; rq[0] = "R4"; en = 1;
        end else if (!hit) begin
            if (mv[ix]) begin
                eop[0] = mp[ix] ? 3'd5 : 3'd4;
                ea[0]  = {mt[ix], ix};
                ed[0]  = md[ix];
                edc[0] = mp[ix];
                rq[0]  = "R6";
                en     = 1;
            end
            eop[en] = st ? 3'd1 : 3'd0;
            ea[en]  = a;
            ed[en]  = '0;
            edc[en] = 0;
            rq[en]  = st ? "R3" : "R2";
            en++;
        end
        main_rq = hit ? (st ? (mp[ix] ? "R5" : "R4") : "R7") : (st ? "R3" : "R2");
        lg_n      = 0;
        cpu_req   = 1'b1;
        cpu_store = st;
        cpu_addr  = a;
        cpu_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ack && cyc < 80);
        cpu_req = 1'b0;
        chk(cpu_ack == 1'b1, main_rq, "ack seen", cpu_ack, 1);
        chk(lg_n == en, main_rq, "request count", lg_n, en);
        for (int k = 0; k < en && k < lg_n; k++) begin
            chk(lg_op[k] == eop[k], rq[k], "request op", lg_op[k], eop[k]);
            chk(lg_addr[k] == ea[k], rq[k], "request addr", lg_addr[k], ea[k]);
            if (edc[k]) chk(lg_data[k] == ed[k], rq[k], "write-back data", lg_data[k], ed[k]);
        end
        if (!st) chk(cpu_rdata == (hit ? md[ix] : emem), main_rq, "load data",
                     cpu_rdata, hit ? md[ix] : emem);
        if (hit && (!st || mp[ix])) chk(cyc == 1, main_rq, "hit ack latency", cyc, 1);
        mv[ix] = 1'b1;
        mt[ix] = tg;
        if (st) begin
            mp[ix] = 1'b1;
            md[ix] = wd;
        end else if (!hit) begin
            mp[ix] = 1'b0;
            md[ix] = emem;
        end
        @(negedge clk);
    endtask

    task automatic do_snoop(input logic purge, input logic [AW-1:0] a);
        logic [1:0] ix;
        bit         held;
        bit         eresp;
        logic [2:0] eop;
        logic [DW-1:0] edat;
        string      rq;
        ix    = a[1:0];
        held  = mv[ix] && (mt[ix] == a[3:2]);
        eresp = 0;
        eop   = 3'd0;
        edat  = md[ix];
        rq    = "R10";
        if (held && purge) begin
            eresp = 1; eop = mp[ix] ? 3'd5 : 3'd4; rq = "R9";
        end else if (held && mp[ix]) begin
            eresp = 1; eop = 3'd3; rq = "R8";
        end
        mcmd_valid = 1'b1;
        mcmd_purge = purge;
        mcmd_addr  = a;
        @(negedge clk);
        mcmd_valid = 1'b0;
        chk(sresp_valid == eresp, rq, "response strobe", sresp_valid, eresp);
        if (eresp && sresp_valid) begin
            chk(sresp_op == eop, rq, "response op", sresp_op, eop);
            chk(sresp_addr == a, rq, "response addr", sresp_addr, a);
            if (eop != 3'd4) begin
                chk(sresp_data == edat, rq, "response data", sresp_data, edat);
                mem[a] = sresp_data;
            end
        end
        if (held && purge) begin
            mv[ix] = 1'b0;
            mp[ix] = 1'b0;
        end else if (held) begin
            mp[ix] = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = DW'(16'hA000 + i * 16'h0111);
        for (int i = 0; i < NL; i++) begin
            mv[i] = 1'b0; mp[i] = 1'b0; mt[i] = '0; md[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ack == 1'b0, "R1", "ack after reset", cpu_ack, 0);
        chk(mreq_valid == 1'b0, "R1", "request after reset", mreq_valid, 0);
        chk(sresp_valid == 1'b0, "R1", "response after reset", sresp_valid, 0);

        // R1: every line starts invalid, so each first access issues only a fill
        for (int i = 0; i < NL; i++) begin
            do_access(1'b0, AW'(i + 4), '0);
            chk(lg_n == 1, "R1", "single fill on first access", lg_n, 1);
        end

        // directed sequence on line 1
        do_access(1'b0, 4'h9, '0);        // R2 miss, evicts 5 with drop (R6)
        do_access(1'b0, 4'h9, '0);        // R7 hit
        do_access(1'b1, 4'h9, 16'h1234);  // R4 ownership request
        do_access(1'b1, 4'h9, 16'h2345);  // R5 owned hit
        do_snoop(1'b0, 4'h9);             // R8 write, line stays valid
        do_access(1'b1, 4'h9, 16'h3456);  // R8 ownership was lost, R4 again
        do_snoop(1'b1, 4'h9);             // R9 write-back-and-drop
        do_access(1'b0, 4'h9, '0);        // R9 line invalid: fill with no eviction
        do_snoop(1'b1, 4'h9);             // R9 drop for unowned line
        do_snoop(1'b0, 4'hD);             // R10 line invalid
        do_access(1'b0, 4'h5, '0);
        do_snoop(1'b0, 4'h5);             // R10 unowned copy-back ignored
        do_snoop(1'b1, 4'h1);             // R10 tag mismatch ignored
        do_access(1'b0, 4'h5, '0);        // R10 still a hit

        // sweep over addresses, operations and latencies
        for (int i = 0; i < 120; i++) begin
            lat = 1 + (i % 3);
            do_access((i % 3) == 0, AW'((i * 5 + i / 4) % 16), DW'(16'h5000 + i));
            if ((i % 4) == 2) do_snoop((i % 8) < 4, AW'((i * 3) % 16));
        end

        // R11: command served while an eviction/fill is outstanding
        lat = 2;
        do_access(1'b1, 4'h0, 16'h0F0F);
        do_access(1'b0, 4'h6, '0);
        lat = 8;
        fork
            do_access(1'b1, 4'hA, 16'hBEEF);
            begin
                repeat (3) @(negedge clk);
                chk(mreq_valid == 1'b1, "R11", "request outstanding", mreq_valid, 1);
                do_snoop(1'b1, 4'h0);
            end
        join

        // R12: take-away of the line whose ownership request is pending
        lat = 2;
        do_access(1'b0, 4'h3, '0);
        lat = 8;
        fork
            do_access(1'b1, 4'h3, 16'hC0DE);
            begin
                repeat (3) @(negedge clk);
                chk(mreq_valid == 1'b1 && mreq_op == 3'd2, "R12", "ownership pending",
                    {mreq_valid, mreq_op}, {1'b1, 3'd2});
                do_snoop(1'b1, 4'h3);
            end
        join
        lat = 2;
        do_access(1'b0, 4'h3, '0);
        chk(cpu_rdata == 16'hC0DE, "R12", "installed block", cpu_rdata, 16'hC0DE);
        do_snoop(1'b0, 4'h3);

        finish_up();
    end

endmodule